// File: doc/BRIEF.md
# Four-Entry Register Stack Processor

This block is a small multi-cycle processor whose only operand store is a four-entry register stack. The stack is built from parallel registers, not from a memory with a pointer. A push moves every entry one place deeper in the same clock. A pop moves every entry one place toward the top in the same clock and loads zero into the deepest entry. Each instruction is fetched from an internal word memory. The fetch path runs through an instruction pointer, a memory address register, a memory data register and an instruction register.

Each instruction is a 16-bit word. The opcode sits in bits 15:12 and a 12-bit field sits in bits 11:0. Four opcodes act on the stack: push an immediate, push a word read from memory, pop the top word into memory, and replace the top two words with their sum. A fifth opcode stops the machine. A test environment fills the memory through a write port while reset is held, releases reset, and waits for the done flag. It then reads the stack through a flat view port.

Top module: `stack_cpu`

## Requirements
- R1: While the synchronous reset is high, every stack entry is zero and done is low. After reset is released, execution starts at address 0.
- R2: Opcode 1 (bits 15:12) pushes bits 11:0 zero-extended to 16 bits. On a push the old top becomes entry 1, entry 1 becomes entry 2 and entry 2 becomes entry 3, all in one clock.
- R3: A push onto a full stack silently discards the old deepest entry (entry 3).
- R4: Opcode 2 pushes the memory word at the address given by the low 8 bits of bits 11:0.
- R5: Opcode 3 pops the top entry into the memory word at the address given by the low 8 bits of bits 11:0. The remaining entries move one place toward the top and entry 3 becomes zero.
- R6: Opcode 4 ignores bits 11:0. It replaces the top two entries with their sum modulo 2^16, moves the deeper entries one place toward the top and clears entry 3.
- R7: A pop or an add on an empty stack uses zeros: a store from an empty stack writes 0, and an add on an empty stack leaves the stack all zero.
- R8: Opcode F stops execution. Done rises and stays high, and the stack holds its value until the next reset.
- R9: Any other opcode (0, 5 to E) leaves the stack and memory unchanged, and execution goes on with the next word.
- R10: Opcodes 1 to 4 each take 6 clocks. Opcodes other than 1 to 4 and F take 4 clocks. Done rises 4 clocks after the fetch of the stop opcode begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the stack, the pointer and the control state |
| loadEn | input | 1 | Write strobe for filling the memory |
| loadAddr | input | 8 | Memory address for a fill write |
| loadData | input | 16 | Data for a fill write |
| done | output | 1 | High once the stop opcode has executed |
| stackView | output | 64 | Stack entries; entry 0 (the top) in bits 15:0, entry 3 in bits 63:48 |

## Verification
The stack is driven with short pushes, with pushes that overfill it, with pops and adds on an empty stack, and with an add whose sum wraps past 16 bits. Together these separate a correct shift from a lost, duplicated or uncleared entry, and a correct sum from a truncated one. A store followed by a load in a later run shows that the value reached the right memory word. Programs that mix undefined opcodes with pushes, and cycle counts taken to done, show that undefined opcodes do nothing and that each instruction class takes the stated number of clocks.

// File: rtl/stack_cpu_pkg.sv
package stack_cpu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_PUSHI = 4'h1,
    OP_LOAD  = 4'h2,
    OP_STORE = 4'h3,
    OP_ADD   = 4'h4,
    OP_HALT  = 4'hF
  } opcode_e;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic marFromIp;
    logic marFromIr;
    logic mdrFromMem;
    logic mdrFromImm;
    logic ipInc;
    logic irLoad;
    logic stPush;
    logic stPop;
    logic stAddSum;
    logic memWrite;
  } ctrl_t;
endpackage

// File: rtl/stack_regs.sv
module stack_regs #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   push,
  input  logic                   pop,
  input  logic                   addSum,
  input  logic [WIDTH-1:0]       pushData,
  output logic [WIDTH-1:0]       topData,
  output logic [DEPTH*WIDTH-1:0] view
);
  logic [WIDTH-1:0] ent   [DEPTH];
  logic [WIDTH-1:0] above [DEPTH];
  logic [WIDTH-1:0] below [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_link
    if (i == 0) begin : g_top
      assign above[i] = pushData;
    end else begin : g_mid
      assign above[i] = ent[i-1];
    end
    if (i == DEPTH-1) begin : g_bot
      assign below[i] = '0;
    end else begin : g_up
      assign below[i] = ent[i+1];
    end
    assign view[i*WIDTH +: WIDTH] = ent[i];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst)       ent[i] <= '0;
      else if (push) ent[i] <= above[i];
      else if (pop)  ent[i] <= below[i];
    end
    if (!rst && !push && !pop && addSum) ent[1] <= ent[0] + ent[1];
  end

  assign topData = ent[0];
endmodule

// File: rtl/stack_cpu_datapath.sv
module stack_cpu_datapath
  import stack_cpu_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int ADDRW = 8,
  parameter int DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  ctrl_t                  ctl,
  input  logic                   loadEn,
  input  logic [ADDRW-1:0]       loadAddr,
  input  logic [WIDTH-1:0]       loadData,
  output logic [OP_W-1:0]        opField,
  output logic [DEPTH*WIDTH-1:0] stackView
);
  localparam int MEM_WORDS = 1 << ADDRW;
  localparam int FIELD_W   = WIDTH - OP_W;

  logic [WIDTH-1:0] mem [MEM_WORDS];
  logic [ADDRW-1:0] ip, mar;
  logic [WIDTH-1:0] mdr, ir, topData, immExt;

  assign immExt  = {{OP_W{1'b0}}, ir[FIELD_W-1:0]};
  assign opField = ir[WIDTH-1 -: OP_W];

  always_ff @(posedge clk) begin
    if (loadEn)            mem[loadAddr] <= loadData;
    else if (ctl.memWrite) mem[mar]      <= mdr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ip  <= '0;
      mar <= '0;
      mdr <= '0;
      ir  <= '0;
    end else begin
      if (ctl.marFromIp)       mar <= ip;
      else if (ctl.marFromIr)  mar <= ir[ADDRW-1:0];
      if (ctl.ipInc)           ip  <= ip + 1'b1;
      if (ctl.irLoad)          ir  <= mdr;
      if (ctl.mdrFromMem)      mdr <= mem[mar];
      else if (ctl.mdrFromImm) mdr <= immExt;
      else if (ctl.stPop)      mdr <= topData;
    end
  end

  stack_regs #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_stack (
    .clk     (clk),
    .rst     (rst),
    .push    (ctl.stPush),
    .pop     (ctl.stPop),
    .addSum  (ctl.stAddSum),
    .pushData(mdr),
    .topData (topData),
    .view    (stackView)
  );
endmodule

// File: rtl/stack_cpu_control.sv
module stack_cpu_control
  import stack_cpu_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opField,
  output ctrl_t           ctl,
  output logic            done
);
  typedef enum logic [3:0] {
    S_FADDR, S_FREAD, S_FIR, S_DEC, S_MEMRD, S_LDIMM, S_PUSH,
    S_POP, S_MEMWR, S_ADDSUM, S_ADDSHIFT, S_HALT
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= S_FADDR;
    else     state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    case (state)
      S_FADDR: begin ctl.marFromIp = 1'b1; nextState = S_FREAD; end
      S_FREAD: begin ctl.mdrFromMem = 1'b1; ctl.ipInc = 1'b1; nextState = S_FIR; end
      S_FIR:   begin ctl.irLoad = 1'b1; nextState = S_DEC; end
      S_DEC: begin
        case (opField)
          OP_PUSHI: nextState = S_LDIMM;
          OP_LOAD:  begin ctl.marFromIr = 1'b1; nextState = S_MEMRD; end
          OP_STORE: begin ctl.marFromIr = 1'b1; nextState = S_POP; end
          OP_ADD:   nextState = S_ADDSUM;
          OP_HALT:  nextState = S_HALT;
          default:  nextState = S_FADDR;
        endcase
      end
      S_MEMRD:    begin ctl.mdrFromMem = 1'b1; nextState = S_PUSH; end
      S_LDIMM:    begin ctl.mdrFromImm = 1'b1; nextState = S_PUSH; end
      S_PUSH:     begin ctl.stPush = 1'b1; nextState = S_FADDR; end
      S_POP:      begin ctl.stPop = 1'b1; nextState = S_MEMWR; end
      S_MEMWR:    begin ctl.memWrite = 1'b1; nextState = S_FADDR; end
      S_ADDSUM:   begin ctl.stAddSum = 1'b1; nextState = S_ADDSHIFT; end
      S_ADDSHIFT: begin ctl.stPop = 1'b1; nextState = S_FADDR; end
      S_HALT:     nextState = S_HALT;
      default:    nextState = S_FADDR;
    endcase
  end

  assign done = (state == S_HALT);
endmodule

// File: rtl/stack_cpu.sv
module stack_cpu
  import stack_cpu_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int ADDRW = 8,
  parameter int DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   loadEn,
  input  logic [ADDRW-1:0]       loadAddr,
  input  logic [WIDTH-1:0]       loadData,
  output logic                   done,
  output logic [DEPTH*WIDTH-1:0] stackView
);
  ctrl_t           ctl;
  logic [OP_W-1:0] opField;

  stack_cpu_control u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opField(opField),
    .ctl    (ctl),
    .done   (done)
  );

  stack_cpu_datapath #(.WIDTH(WIDTH), .ADDRW(ADDRW), .DEPTH(DEPTH)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .loadEn   (loadEn),
    .loadAddr (loadAddr),
    .loadData (loadData),
    .opField  (opField),
    .stackView(stackView)
  );
endmodule

// File: rtl/stack_cpu_chk.sv
module stack_cpu_chk #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   pushStb,
  input logic                   popStb,
  input logic                   addStb,
  input logic                   done,
  input logic [DEPTH*WIDTH-1:0] stackView
);
  logic [WIDTH-1:0] topE, secondE, thirdLastE, deepE;
  assign topE       = stackView[WIDTH-1:0];
  assign secondE    = stackView[2*WIDTH-1:WIDTH];
  assign thirdLastE = stackView[(DEPTH-1)*WIDTH-1 -: WIDTH];
  assign deepE      = stackView[DEPTH*WIDTH-1 -: WIDTH];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (stackView == '0 && !done));

  // R2
  push_shift_chk: assert property (@(posedge clk) disable iff (rst)
    pushStb |=> secondE == $past(topE));

  // R3
  push_drop_chk: assert property (@(posedge clk) disable iff (rst)
    pushStb |=> deepE == $past(thirdLastE));

  // R5
  pop_shift_chk: assert property (@(posedge clk) disable iff (rst)
    popStb |=> (deepE == '0 && topE == $past(secondE)));

  // R6
  add_sum_chk: assert property (@(posedge clk) disable iff (rst)
    addStb |=> secondE == WIDTH'($past(topE) + $past(secondE)));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pushStb, popStb, addStb}));

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && $stable(stackView)));
endmodule

bind stack_cpu stack_cpu_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pushStb  (ctl.stPush),
  .popStb   (ctl.stPop),
  .addStb   (ctl.stAddSum),
  .done     (done),
  .stackView(stackView)
);

// File: tb/stack_cpu_test.sv
module stack_cpu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadEn = 1'b0;
  logic [7:0]  loadAddr = '0;
  logic [15:0] loadData = '0;
  logic        done;
  logic [63:0] stackView;

  int checks = 0;
  int errors = 0;

  stack_cpu uut (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .done(done), .stackView(stackView)
  );

  always #4 clk = ~clk;

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] f);
    return {op, f};
  endfunction

  function automatic logic [63:0] stk(input logic [15:0] e0, e1, e2, e3);
    return {e3, e2, e1, e0};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic holdReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
  endtask

  task automatic put(input logic [7:0] a, input logic [15:0] d);
    loadEn = 1'b1; loadAddr = a; loadData = d;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  // Releases reset and counts clocks until done (0 if it never comes)
  task automatic run(output int cycles);
    int n = 0;
    rst = 1'b0;
    while (!done && n < 400) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    cycles = done ? n : 0;
  endtask

  task automatic testPush();
    int c;
    holdReset();
    put(0, ins(4'h1, 12'h001));
    put(1, ins(4'h1, 12'hFFF));
    put(2, ins(4'hF, 12'h000));
    run(c);
    check("R2 push order and zero-extension", stackView, stk(16'h0FFF, 16'h0001, 0, 0));
    check("R8 done after stop", {63'd0, done}, 64'd1);
    check("R10 clocks to done", c, 16);
  endtask

  task automatic testResetClear();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 stack cleared by reset", stackView, 64'd0);
    check("R1 done low in reset", {63'd0, done}, 64'd0);
  endtask

  task automatic testOverfill();
    int c;
    holdReset();
    for (int i = 0; i < 5; i++) put(8'(i), ins(4'h1, 12'(i + 1)));
    put(5, ins(4'hF, 0));
    run(c);
    check("R3 deepest entry dropped", stackView, stk(5, 4, 3, 2));
  endtask

  task automatic testAddStore();
    int c;
    holdReset();
    put(8'h50, 16'hDEAD);
    put(0, ins(4'h1, 1));
    put(1, ins(4'h1, 2));
    put(2, ins(4'h4, 12'hABC));
    put(3, ins(4'h3, 12'h050));
    put(4, ins(4'hF, 0));
    run(c);
    check("R5 stack empty after store", stackView, 64'd0);
    check("R10 clocks for four ops plus stop", c, 28);
    holdReset();
    put(0, ins(4'h2, 12'h050));
    put(1, ins(4'hF, 0));
    run(c);
    check("R4 load returns stored sum (R5 memory write)", stackView, stk(3, 0, 0, 0));
  endtask

  task automatic testAddDeep();
    int c;
    holdReset();
    put(8'h60, 16'hFFFF);
    put(0, ins(4'h1, 7));
    put(1, ins(4'h2, 12'h060));
    put(2, ins(4'h1, 2));
    put(3, ins(4'h4, 0));
    put(4, ins(4'hF, 0));
    run(c);
    check("R6 wrapped sum and shift", stackView, stk(16'h0001, 7, 0, 0));
    holdReset();
    put(0, ins(4'h1, 7));
    put(1, ins(4'h1, 8));
    put(2, ins(4'h1, 9));
    put(3, ins(4'h4, 0));
    put(4, ins(4'hF, 0));
    run(c);
    check("R6 deeper entries move up", stackView, stk(17, 7, 0, 0));
  endtask

  task automatic testUnderflow();
    int c;
    holdReset();
    put(8'h70, 16'h1234);
    put(0, ins(4'h4, 0));
    put(1, ins(4'h3, 12'h070));
    put(2, ins(4'hF, 0));
    run(c);
    check("R7 add on empty stays zero", stackView, 64'd0);
    holdReset();
    put(0, ins(4'h2, 12'h070));
    put(1, ins(4'hF, 0));
    run(c);
    check("R7 store from empty wrote zero", stackView, 64'd0);
  endtask

  task automatic testUnknown();
    int c;
    holdReset();
    put(8'h20, 16'h4321);
    put(0, ins(4'h1, 5));
    put(1, ins(4'h5, 12'h020));
    put(2, ins(4'h0, 12'h020));
    put(3, ins(4'hE, 12'h020));
    put(4, ins(4'h1, 6));
    put(5, ins(4'h2, 12'h020));
    put(6, ins(4'hF, 0));
    run(c);
    check("R9 undefined opcodes do nothing", stackView, stk(16'h4321, 6, 5, 0));
    check("R10 undefined opcodes take 4 clocks", c, 34);
  endtask

  task automatic testHaltHold();
    logic [63:0] snap;
    snap = stackView;
    repeat (10) @(negedge clk);
    check("R8 stack frozen after stop", stackView, snap);
    check("R8 done stays high", {63'd0, done}, 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testPush();
    testHaltHold();
    testResetClear();
    testOverfill();
    testAddStore();
    testAddDeep();
    testUnderflow();
    testUnknown();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule